// File: doc/BRIEF.md
# FIFO Fill-Level Status and Watermark Interrupts

This block watches a receive FIFO and a transmit FIFO of equal, power-of-two depth. The FIFO storage sits elsewhere: only each FIFO's occupancy count comes in. From those counts the block derives a coarse three-bit fill code for each direction. The receive code measures fullness and the transmit code measures emptiness. Each direction also drives a data-request line, which is high while its code meets a selectable threshold.

A second, independent threshold per direction marks an urgent watermark. Meeting it, a receive overrun, a transmit underrun, or a start or finish pulse from either direction sets a bit in a sticky flag register. A mask register chooses which flags reach the single interrupt output. Software writes these registers only through aliases: one alias sets mask bits, one clears mask bits, and one clears flag bits. The bus decode that produces the alias write strobes is outside the block.

All outputs are registered. They reflect inputs sampled at the previous rising clock edge.

Top module: `fifo_level_watch`

## Requirements
- R1: `rx_level` encodes receive fullness with DEPTH=8. Code 4 means full (8 entries). Code 3 means at least three quarters (6 or 7). Code 2 means at least half (4 or 5). Code 1 means at least a quarter (2 or 3). Code 0 means below a quarter (0 or 1). It appears one clock after the count is sampled.
- R2: `tx_level` applies the same quartile coding to transmit emptiness, which is DEPTH minus `tx_fill`. Code 4 means the FIFO is empty and code 0 means fewer than a quarter of the entries are free.
- R3: Request selects use these codes. 0 and 6–7 keep the request low. 1 means non-zero. 2, 3 and 4 mean at least 25%, 50% and 75%. 5 means the extreme. Receive compares against fullness, so code 1 means not empty. Transmit compares against emptiness, so code 1 means not full.
- R4: Urgent selects use these codes. 0 and 5–7 are disabled. 1, 2 and 3 mean at least 25%, 50% and 75%. 4 means the extreme, full for receive and empty for transmit. While met, the condition sets flag bit 1 for receive and flag bit 2 for transmit. The bit stays set after the condition ends.
- R5: A push while the receive count equals DEPTH sets flag bit 4 (overrun). A pull while the transmit count is 0 sets flag bit 5 (underrun). The same stimulus with one free or one filled entry sets neither bit.
- R6: Pulses on `rx_start`, `tx_start`, `rx_done` and `tx_done` set flag bits 8, 9, 10 and 11 respectively.
- R7: A write on `flag_clr_we` clears every flag bit where `wr_data` is 1. Bits 0, 3, 6 and 7 of `flags` and `mask` always read 0.
- R8: If a clear and a setting cause meet on the same flag bit in the same cycle, the bit ends set.
- R9: `mask_set_we` sets and `mask_clr_we` clears the mask bits selected by `wr_data`. When both strobes hit the same bit in one cycle, the bit ends set.
- R10: `irq` is high exactly when some flag bit and its mask bit are both 1, on the same clock edge that updates those registers.
- R11: During reset the levels, the requests, `flags`, `mask` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill | input | $clog2(DEPTH)+1 | Receive FIFO occupancy |
| tx_fill | input | $clog2(DEPTH)+1 | Transmit FIFO occupancy |
| rx_push | input | 1 | A received word is being written this cycle |
| tx_pull | input | 1 | The shifter takes a transmit word this cycle |
| rx_start | input | 1 | Receive start event pulse |
| tx_start | input | 1 | Transmit start event pulse |
| rx_done | input | 1 | Receive finish event pulse |
| tx_done | input | 1 | Transmit finish event pulse |
| rx_req_sel | input | 3 | Receive request threshold select |
| tx_req_sel | input | 3 | Transmit request threshold select |
| rx_urg_sel | input | 3 | Receive urgent watermark select |
| tx_urg_sel | input | 3 | Transmit urgent watermark select |
| mask_set_we | input | 1 | Mask write-one-to-set strobe |
| mask_clr_we | input | 1 | Mask write-one-to-clear strobe |
| flag_clr_we | input | 1 | Flag write-one-to-clear strobe |
| wr_data | input | 12 | Bit vector for the alias writes |
| rx_level | output | 3 | Receive fullness code |
| tx_level | output | 3 | Transmit emptiness code |
| rx_dreq | output | 1 | Receive data request |
| tx_dreq | output | 1 | Transmit data request |
| flags | output | 12 | Sticky flag register |
| mask | output | 12 | Interrupt mask register |
| irq | output | 1 | Masked interrupt output |

## Verification
The assertions check several properties on every cycle. They check that flags stay sticky unless cleared and that a setting cause always overrides a same-cycle clear. They check that mask set writes take effect and that `irq` tracks the masked flags. They check that a level code never exceeds 4, that a full or empty FIFO yields code 4, and that a disabled request select keeps the request low. The bench scenarios are needed for the exact quartile boundaries at every count and for each request code against every fill value. They are also needed for the one-entry margins around overrun and underrun, and for the set-wins collision on the mask.

// File: rtl/fifo_stat_pkg.sv
package fifo_stat_pkg;

  localparam int FLAG_W = 12;

  // flag bit positions (decoded by software)
  localparam int B_RX_WM    = 1;
  localparam int B_TX_WM    = 2;
  localparam int B_RX_OVR   = 4;
  localparam int B_TX_UDR   = 5;
  localparam int B_RX_START = 8;
  localparam int B_TX_START = 9;
  localparam int B_RX_DONE  = 10;
  localparam int B_TX_DONE  = 11;

  localparam logic [FLAG_W-1:0] FLAG_IMPL = 12'hF36;

  // quartile code of an amount against a depth
  function automatic logic [2:0] quart_code(input int unsigned amt,
                                            input int unsigned depth);
    if (amt >= depth)             return 3'd4;
    else if (4 * amt >= 3 * depth) return 3'd3;
    else if (4 * amt >= 2 * depth) return 3'd2;
    else if (4 * amt >= depth)     return 3'd1;
    else                           return 3'd0;
  endfunction

  // request threshold: 1 non-zero, 2..4 quarters, 5 extreme
  function automatic logic req_hit(input logic [2:0] sel,
                                   input int unsigned amt,
                                   input int unsigned depth);
    case (sel)
      3'd1:    return amt != 0;
      3'd2:    return 4 * amt >= depth;
      3'd3:    return 4 * amt >= 2 * depth;
      3'd4:    return 4 * amt >= 3 * depth;
      3'd5:    return amt >= depth;
      default: return 1'b0;
    endcase
  endfunction

  // urgent threshold: 1..3 quarters, 4 extreme
  function automatic logic urg_hit(input logic [2:0] sel,
                                   input int unsigned amt,
                                   input int unsigned depth);
    case (sel)
      3'd1:    return 4 * amt >= depth;
      3'd2:    return 4 * amt >= 2 * depth;
      3'd3:    return 4 * amt >= 3 * depth;
      3'd4:    return amt >= depth;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fill_side.sv
module fill_side
  import fifo_stat_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter bit BY_EMPTY = 1'b0,
  localparam int CW      = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic [2:0]    req_sel,
  input  logic [2:0]    urg_sel,
  output logic [2:0]    level,
  output logic          dreq,
  output logic          urgent
);

  localparam int unsigned DU = DEPTH;

  int unsigned cnt_u;
  int unsigned amt;

  always_comb begin
    cnt_u = 32'(count);
    if (cnt_u > DU) cnt_u = DU;
    amt    = BY_EMPTY ? (DU - cnt_u) : cnt_u;
    urgent = urg_hit(urg_sel, amt, DU);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 3'd0;
      dreq  <= 1'b0;
    end else begin
      level <= quart_code(amt, DU);
      dreq  <= req_hit(req_sel, amt, DU);
    end
  end

  // R1 / R2: extreme occupancy gives the top code
  assert_extreme_code_R1: assert property (@(posedge clk) disable iff (rst)
    (amt == DU) |=> (level == 3'd4));

  assert_level_range_R1: assert property (@(posedge clk) disable iff (rst)
    level <= 3'd4);

  // R3: disabled select keeps the request low
  assert_req_off_R3: assert property (@(posedge clk) disable iff (rst)
    (req_sel == 3'd0 || req_sel > 3'd5) |=> !dreq);

endmodule

// File: rtl/flag_latch.sv
module flag_latch
  import fifo_stat_pkg::*;
#(
  parameter int             W    = FLAG_W,
  parameter logic [W-1:0]   IMPL = FLAG_IMPL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic         mset_we,
  input  logic         mclr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] mask,
  output logic         irq
);

  logic [W-1:0] flags_d;
  logic [W-1:0] mask_d;
  logic         past_ok;

  always_comb begin
    flags_d = flags;
    if (clr_we) flags_d = flags_d & ~wdata;
    flags_d = (flags_d | set_vec) & IMPL;   // cause beats clear
    mask_d = mask;
    if (mclr_we) mask_d = mask_d & ~wdata;
    if (mset_we) mask_d = mask_d | wdata;   // set beats clear
    mask_d = mask_d & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      mask    <= '0;
      irq     <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      flags   <= flags_d;
      mask    <= mask_d;
      irq     <= |(flags_d & mask_d);
      past_ok <= 1'b1;
    end
  end

  // R4: a flag never drops without a clear write on it
  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((($past(flags) & ~($past(clr_we) ? $past(wdata) : '0)) & ~flags) == '0));

  // R8: any setting cause leaves its bit set
  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(set_vec) & IMPL & ~flags) == '0));

  // R9: a set write always lands
  assert_mask_set_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mset_we)) |-> (($past(wdata) & IMPL & ~mask) == '0));

  // R10: interrupt follows masked flags
  assert_irq_match_R10: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & mask));

endmodule

// File: rtl/fifo_level_watch.sv
module fifo_level_watch
  import fifo_stat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     rx_fill,
  input  logic [CW-1:0]     tx_fill,
  input  logic              rx_push,
  input  logic              tx_pull,
  input  logic              rx_start,
  input  logic              tx_start,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic [2:0]        rx_req_sel,
  input  logic [2:0]        tx_req_sel,
  input  logic [2:0]        rx_urg_sel,
  input  logic [2:0]        tx_urg_sel,
  input  logic              mask_set_we,
  input  logic              mask_clr_we,
  input  logic              flag_clr_we,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [2:0]        rx_level,
  output logic [2:0]        tx_level,
  output logic              rx_dreq,
  output logic              tx_dreq,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] mask,
  output logic              irq
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic              rx_urgent;
  logic              tx_urgent;
  logic [FLAG_W-1:0] set_vec;

  fill_side #(.DEPTH(DEPTH), .BY_EMPTY(1'b0)) u_rx (
    .clk(clk), .rst(rst), .count(rx_fill), .req_sel(rx_req_sel),
    .urg_sel(rx_urg_sel), .level(rx_level), .dreq(rx_dreq), .urgent(rx_urgent)
  );

  fill_side #(.DEPTH(DEPTH), .BY_EMPTY(1'b1)) u_tx (
    .clk(clk), .rst(rst), .count(tx_fill), .req_sel(tx_req_sel),
    .urg_sel(tx_urg_sel), .level(tx_level), .dreq(tx_dreq), .urgent(tx_urgent)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[B_RX_WM]    = rx_urgent;
    set_vec[B_TX_WM]    = tx_urgent;
    set_vec[B_RX_OVR]   = rx_push && (rx_fill >= FULL_CNT);
    set_vec[B_TX_UDR]   = tx_pull && (tx_fill == '0);
    set_vec[B_RX_START] = rx_start;
    set_vec[B_TX_START] = tx_start;
    set_vec[B_RX_DONE]  = rx_done;
    set_vec[B_TX_DONE]  = tx_done;
  end

  flag_latch #(.W(FLAG_W), .IMPL(FLAG_IMPL)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_we(flag_clr_we),
    .mset_we(mask_set_we), .mclr_we(mask_clr_we), .wdata(wr_data),
    .flags(flags), .mask(mask), .irq(irq)
  );

  // R5: overrun and underrun reach the flag register
  assert_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_fill == FULL_CNT) |=> flags[B_RX_OVR]);

  assert_underrun_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_pull && tx_fill == '0) |=> flags[B_TX_UDR]);

  // R6: event pulses reach the flag register
  assert_events_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_start || tx_done) |=> (flags[B_RX_START] || flags[B_TX_DONE]));

endmodule

// File: tb/tb_fifo_level_watch.sv
`timescale 1ns/1ps
module tb_fifo_level_watch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rx_fill = '0, tx_fill = '0;
  logic        rx_push = 0, tx_pull = 0;
  logic        rx_start = 0, tx_start = 0, rx_done = 0, tx_done = 0;
  logic [2:0]  rx_req_sel = 0, tx_req_sel = 0, rx_urg_sel = 0, tx_urg_sel = 0;
  logic        mask_set_we = 0, mask_clr_we = 0, flag_clr_we = 0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rx_level, tx_level;
  logic        rx_dreq, tx_dreq, irq;
  logic [11:0] flags, mask;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fifo_level_watch #(.DEPTH(8)) dut (
    .clk(clk), .rst(rst), .rx_fill(rx_fill), .tx_fill(tx_fill),
    .rx_push(rx_push), .tx_pull(tx_pull), .rx_start(rx_start),
    .tx_start(tx_start), .rx_done(rx_done), .tx_done(tx_done),
    .rx_req_sel(rx_req_sel), .tx_req_sel(tx_req_sel),
    .rx_urg_sel(rx_urg_sel), .tx_urg_sel(tx_urg_sel),
    .mask_set_we(mask_set_we), .mask_clr_we(mask_clr_we),
    .flag_clr_we(flag_clr_we), .wr_data(wr_data),
    .rx_level(rx_level), .tx_level(tx_level), .rx_dreq(rx_dreq),
    .tx_dreq(tx_dreq), .flags(flags), .mask(mask), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int exp_code(input int a);
    if (a == 8) return 4;
    if (a >= 6) return 3;
    if (a >= 4) return 2;
    if (a >= 2) return 1;
    return 0;
  endfunction

  function automatic int exp_req(input int sel, input int a);
    case (sel)
      1: return (a > 0) ? 1 : 0;
      2: return (a >= 2) ? 1 : 0;
      3: return (a >= 4) ? 1 : 0;
      4: return (a >= 6) ? 1 : 0;
      5: return (a == 8) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic clear_flags(input logic [11:0] v);
    flag_clr_we = 1; wr_data = v; tick(); flag_clr_we = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick();
    chk("R11", "rx_level", rx_level, 0);
    chk("R11", "tx_level", tx_level, 0);
    chk("R11", "dreq", {rx_dreq, tx_dreq}, 0);
    chk("R11", "flags", flags, 0);
    chk("R11", "mask", mask, 0);
    chk("R11", "irq", irq, 0);
    rst = 0; tick();
  endtask

  task automatic t_rx_levels();
    for (int c = 0; c <= 8; c++) begin
      rx_fill = 4'(c); tick();
      chk("R1", $sformatf("rx_level cnt=%0d", c), rx_level, exp_code(c));
    end
    rx_fill = 0;
  endtask

  task automatic t_tx_levels();
    for (int c = 0; c <= 8; c++) begin
      tx_fill = 4'(c); tick();
      chk("R2", $sformatf("tx_level cnt=%0d", c), tx_level, exp_code(8 - c));
    end
    tx_fill = 0;
  endtask

  task automatic t_dreq();
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c <= 8; c++) begin
        rx_req_sel = 3'(s); tx_req_sel = 3'(s);
        rx_fill = 4'(c); tx_fill = 4'(c); tick();
        chk("R3", $sformatf("rx_dreq sel=%0d cnt=%0d", s, c), rx_dreq, exp_req(s, c));
        chk("R3", $sformatf("tx_dreq sel=%0d cnt=%0d", s, c), tx_dreq, exp_req(s, 8 - c));
      end
    end
    rx_req_sel = 0; tx_req_sel = 0; rx_fill = 0; tx_fill = 0; tick();
  endtask

  task automatic t_urgent();
    rx_urg_sel = 3'd2; rx_fill = 4'd3; tick();
    chk("R4", "rx wm below half", flags[1], 0);
    rx_fill = 4'd4; tick();
    chk("R4", "rx wm at half", flags[1], 1);
    rx_fill = 4'd0; tick();
    chk("R4", "rx wm sticky", flags[1], 1);
    clear_flags(12'h002);
    chk("R7", "rx wm cleared", flags[1], 0);
    rx_urg_sel = 0;
    tx_urg_sel = 3'd4; tx_fill = 4'd1; tick();
    chk("R4", "tx wm one used", flags[2], 0);
    tx_fill = 4'd0; tick();
    chk("R4", "tx wm empty", flags[2], 1);
    clear_flags(12'h004);
    chk("R8", "tx wm held by cause", flags[2], 1);
    tx_urg_sel = 0; clear_flags(12'h004);
    chk("R7", "tx wm cleared", flags[2], 0);
  endtask

  task automatic t_errors();
    rx_fill = 4'd7; rx_push = 1; tick(); rx_push = 0;
    chk("R5", "no overrun at 7", flags[4], 0);
    rx_fill = 4'd8; rx_push = 1; tick(); rx_push = 0;
    chk("R5", "overrun at full", flags[4], 1);
    tx_fill = 4'd1; tx_pull = 1; tick(); tx_pull = 0;
    chk("R5", "no underrun at 1", flags[5], 0);
    tx_fill = 4'd0; tx_pull = 1; tick(); tx_pull = 0;
    chk("R5", "underrun at empty", flags[5], 1);
    rx_fill = 0;
    clear_flags(12'h030);
    chk("R7", "error flags cleared", flags, 0);
  endtask

  task automatic t_events();
    rx_start = 1; tick(); rx_start = 0;
    chk("R6", "rx start", flags, 12'h100);
    tx_start = 1; tick(); tx_start = 0;
    rx_done = 1; tick(); rx_done = 0;
    tx_done = 1; tick(); tx_done = 0;
    chk("R6", "all events", flags, 12'hF00);
    clear_flags(12'hFFF);
    chk("R7", "clear all", flags, 0);
  endtask

  task automatic t_collide();
    rx_start = 1; tick(); rx_start = 0;
    rx_start = 1; flag_clr_we = 1; wr_data = 12'h100; tick();
    rx_start = 0; flag_clr_we = 0; wr_data = '0;
    chk("R8", "event beats clear", flags[8], 1);
    clear_flags(12'h100);
    chk("R7", "clear after collide", flags[8], 0);
  endtask

  task automatic t_mask();
    mask_set_we = 1; wr_data = 12'hFFF; tick(); mask_set_we = 0;
    chk("R9", "unimplemented mask bits", mask, 12'hF36);
    mask_clr_we = 1; wr_data = 12'hFFF; tick(); mask_clr_we = 0;
    chk("R9", "mask cleared", mask, 0);
    mask_set_we = 1; mask_clr_we = 1; wr_data = 12'h020; tick();
    mask_set_we = 0; mask_clr_we = 0;
    chk("R9", "set beats clear", mask, 12'h020);
    mask_clr_we = 1; wr_data = 12'h020; tick(); mask_clr_we = 0; wr_data = '0;
    chk("R9", "mask empty again", mask, 0);
  endtask

  task automatic t_irq();
    mask_set_we = 1; wr_data = 12'h010; tick(); mask_set_we = 0; wr_data = '0;
    chk("R10", "irq idle", irq, 0);
    rx_fill = 4'd8; rx_push = 1; tick(); rx_push = 0; rx_fill = 0;
    chk("R10", "irq on masked overrun", irq, 1);
    mask_clr_we = 1; wr_data = 12'h010; tick(); mask_clr_we = 0; wr_data = '0;
    chk("R10", "irq off when masked out", irq, 0);
    chk("R4", "flag kept under mask", flags[4], 1);
    tx_done = 1; tick(); tx_done = 0;
    chk("R10", "unmasked event no irq", irq, 0);
    mask_set_we = 1; wr_data = 12'h800; tick(); mask_set_we = 0; wr_data = '0;
    chk("R10", "irq on mask enable", irq, 1);
    clear_flags(12'hFFF);
    chk("R10", "irq after clear", irq, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    tick();
    t_reset();
    t_rx_levels();
    t_tx_levels();
    t_dreq();
    t_urgent();
    t_errors();
    t_events();
    t_collide();
    t_mask();
    t_irq();
    done = 1;
    summary();
  end

endmodule